// File: doc/BRIEF.md
# Block-Floating-Point Pass Scaler

This block sits between the passes of a multi-pass radix-4 FFT datapath. It takes in one block of complex fixed-point values, the pre-rounding products of a pass, which may carry up to three bits of growth beyond the output word. It gathers the whole block and notes its dynamic range as the samples arrive. It then chooses one right shift for every sample of that block and streams the block back out, rounded and saturated to the output word. Each sample keeps its own mantissa, and the whole block shares one exponent.

The shifts chosen for the passes of a transform are summed into a block exponent. The sum is cleared by the first sample of a block flagged as the start of a new transform. When a block is flagged as the final pass, its exponent is presented together with its last output sample. The final output times two to the power of that exponent approximates the full-precision transform. There is no exponent input: incoming values always carry an implied exponent of zero. Two storage banks alternate, so one block can fill while the previous one drains.

Top module: `bfp_pass_scaler`

## Requirements
- R1: While reset is high and after it is released, `out_valid`, `out_last` and `exp_valid` are low and `exp_out` is zero, until a block has been sent.
- R2: A block uses one shift s, the smallest value in 0..MAX_SHIFT for which every real and imaginary component x of the block satisfies -2^(OUT_W-1+s) <= x < 2^(OUT_W-1+s).
- R3: Each component is output as floor((x + 2^(s-1)) / 2^s) when s > 0 (round half up), and unchanged when s = 0.
- R4: A rounded value above 2^(OUT_W-1)-1 is output as 2^(OUT_W-1)-1, and a value below -2^(OUT_W-1) is output as -2^(OUT_W-1).
- R5: The k-th sample (k counted from 0) of a block appears on the output after the (k+1)-th rising edge that follows the edge accepting that block's last input sample. Samples keep their input order on consecutive cycles, and `out_last` marks the BLOCK_LEN-th sample. `out_valid` is low otherwise.
- R6: The exponent is the sum of the shifts of every block from the most recent block whose first sample had `in_new_xform` high, up to and including the current block.
- R7: For a block whose last input sample had `in_final` high, `exp_valid` is high for exactly the cycle of its `out_last`, and `exp_out` then shows the R6 sum. `exp_out` holds that value until the next final block.
- R8: A block not flagged final never raises `exp_valid` and leaves `exp_out` unchanged.
- R9: A new block may begin on the cycle right after the previous block's last sample, and every block is then output completely and correctly.
- R10: After a transform whose passes each grow the data by 4 and each need a shift of at least 2, every final output times 2^`exp_out` is within (number of passes) x 2^`exp_out` of the full-precision result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_last | input | 1 | Input sample is the last of its block |
| in_new_xform | input | 1 | On a block's first sample: a new transform starts, clear the exponent |
| in_final | input | 1 | On a block's last sample: this block is the final pass |
| in_re | input | OUT_W+MAX_SHIFT | Real part of the pre-rounding product, two's complement |
| in_im | input | OUT_W+MAX_SHIFT | Imaginary part of the pre-rounding product, two's complement |
| out_valid | output | 1 | Scaled sample present this cycle |
| out_last | output | 1 | Scaled sample is the last of its block |
| out_re | output | OUT_W | Scaled real part, two's complement |
| out_im | output | OUT_W | Scaled imaginary part, two's complement |
| exp_valid | output | 1 | Block exponent is presented with this last sample |
| exp_out | output | EXP_W | Accumulated block exponent, unsigned |

## Verification
The assertions assume that each block is exactly BLOCK_LEN valid samples long, with `in_last` on the last of them. They also assume that a new block never finishes before the block ahead of it has drained. The bench only ever sends whole blocks, either back to back or separated by idle gaps of at least a block length, so both assumptions always hold. The bench also picks its full-scale test values so that the multi-pass comparison never hits saturation.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

    localparam int SHIFT_BITS = 3;

    typedef logic [SHIFT_BITS-1:0] shift_t;

    typedef enum logic {
        RD_IDLE,
        RD_RUN
    } rd_state_t;

    typedef struct packed {
        logic   new_xform;
        logic   final_blk;
        shift_t shift;
    } blk_meta_t;

    // Smallest shift that brings a ones-complement magnitude below 2^(out_w-1).
    function automatic shift_t pick_shift(input logic [63:0] peak,
                                          input int out_w,
                                          input int max_shift);
        shift_t s;
        s = shift_t'(max_shift);
        for (int k = max_shift; k >= 0; k--) begin
            if ((peak >> (out_w - 1 + k)) == 64'd0) begin
                s = shift_t'(k);
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/bfp_range_meter.sv
module bfp_range_meter
    import bfp_pkg::*;
#(
    parameter  int IN_W      = 19,
    parameter  int OUT_W     = 16,
    parameter  int MAX_SHIFT = 3,
    parameter  int BLOCK_LEN = 16,
    localparam int IDX_W     = $clog2(BLOCK_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             in_new_xform,
    input  logic             in_final,
    input  logic [IN_W-1:0]  in_re,
    input  logic [IN_W-1:0]  in_im,
    output logic [IDX_W-1:0] wr_idx,
    output logic             wr_bank,
    output logic             launch,
    output blk_meta_t        launch_meta
);

    logic            in_block_q;
    logic            new_q;
    logic [IN_W-1:0] peak_q;
    logic [IN_W-1:0] mag_re;
    logic [IN_W-1:0] mag_im;
    logic [IN_W-1:0] peak_nxt;

    always_comb begin
        // Ones-complement magnitude: -2^k maps to 2^k-1, matching the signed range.
        mag_re   = in_re[IN_W-1] ? ~in_re : in_re;
        mag_im   = in_im[IN_W-1] ? ~in_im : in_im;
        peak_nxt = (in_block_q ? peak_q : '0) | mag_re | mag_im;

        launch                = in_valid && in_last;
        launch_meta.new_xform = in_block_q ? new_q : in_new_xform;
        launch_meta.final_blk = in_final;
        launch_meta.shift     = pick_shift(64'(peak_nxt), OUT_W, MAX_SHIFT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_block_q <= 1'b0;
            new_q      <= 1'b0;
            peak_q     <= '0;
            wr_idx     <= '0;
            wr_bank    <= 1'b0;
        end else if (in_valid) begin
            if (in_last) begin
                in_block_q <= 1'b0;
                peak_q     <= '0;
                wr_idx     <= '0;
                wr_bank    <= ~wr_bank;
            end else begin
                in_block_q <= 1'b1;
                peak_q     <= peak_nxt;
                wr_idx     <= wr_idx + IDX_W'(1);
                if (!in_block_q) begin
                    new_q <= in_new_xform;
                end
            end
        end
    end

endmodule

// File: rtl/bfp_block_store.sv
module bfp_block_store #(
    parameter  int IN_W      = 19,
    parameter  int BLOCK_LEN = 16,
    localparam int IDX_W     = $clog2(BLOCK_LEN),
    localparam int BANKS     = 2
) (
    input  logic             clk,
    input  logic             we,
    input  logic             wbank,
    input  logic [IDX_W-1:0] widx,
    input  logic [IN_W-1:0]  wre,
    input  logic [IN_W-1:0]  wim,
    input  logic             rbank,
    input  logic [IDX_W-1:0] ridx,
    output logic [IN_W-1:0]  rre,
    output logic [IN_W-1:0]  rim
);

    logic [IN_W-1:0] bank_re [BANKS];
    logic [IN_W-1:0] bank_im [BANKS];

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [IN_W-1:0] mem_re [BLOCK_LEN];
        logic [IN_W-1:0] mem_im [BLOCK_LEN];

        always_ff @(posedge clk) begin
            if (we && (wbank == 1'(b))) begin
                mem_re[widx] <= wre;
                mem_im[widx] <= wim;
            end
        end

        assign bank_re[b] = mem_re[ridx];
        assign bank_im[b] = mem_im[ridx];
    end

    assign rre = bank_re[rbank];
    assign rim = bank_im[rbank];

endmodule

// File: rtl/bfp_round_shift.sv
module bfp_round_shift
    import bfp_pkg::*;
#(
    parameter int IN_W  = 19,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  x,
    input  shift_t           sh,
    output logic [OUT_W-1:0] y
);

    localparam logic signed [IN_W:0] MAXV = {{(IN_W-OUT_W+2){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [IN_W:0] MINV = ~MAXV;

    logic signed [IN_W:0] ext;
    logic signed [IN_W:0] bias;
    logic signed [IN_W:0] sum;
    logic signed [IN_W:0] shifted;

    always_comb begin
        ext     = $signed({x[IN_W-1], x});
        bias    = $signed(((IN_W+1)'(1) << sh) >> 1);
        sum     = ext + bias;
        shifted = sum >>> sh;
        if (shifted > MAXV) begin
            y = MAXV[OUT_W-1:0];
        end else if (shifted < MINV) begin
            y = MINV[OUT_W-1:0];
        end else begin
            y = shifted[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/bfp_exp_accum.sv
module bfp_exp_accum
    import bfp_pkg::*;
#(
    parameter int EXP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  blk_meta_t        meta,
    output logic [EXP_W-1:0] exp_acc
);

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_acc <= '0;
        end else if (launch) begin
            exp_acc <= (meta.new_xform ? '0 : exp_acc) + EXP_W'(meta.shift);
        end
    end

endmodule

// File: rtl/bfp_pass_scaler.sv
module bfp_pass_scaler
    import bfp_pkg::*;
#(
    parameter  int OUT_W     = 16,
    parameter  int MAX_SHIFT = 3,
    parameter  int BLOCK_LEN = 16,
    parameter  int EXP_W     = 6,
    localparam int IN_W      = OUT_W + MAX_SHIFT,
    localparam int IDX_W     = $clog2(BLOCK_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic             in_new_xform,
    input  logic             in_final,
    input  logic [IN_W-1:0]  in_re,
    input  logic [IN_W-1:0]  in_im,
    output logic             out_valid,
    output logic             out_last,
    output logic [OUT_W-1:0] out_re,
    output logic [OUT_W-1:0] out_im,
    output logic             exp_valid,
    output logic [EXP_W-1:0] exp_out
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_LEN - 1);

    logic [IDX_W-1:0] wr_idx;
    logic             wr_bank;
    logic             launch;
    blk_meta_t        launch_meta;
    logic [EXP_W-1:0] exp_acc;

    rd_state_t        rd_state;
    logic [IDX_W-1:0] rd_idx;
    logic             rd_bank;
    blk_meta_t        rd_meta;
    logic             rd_end;

    logic [IN_W-1:0]  comp_in  [2];
    logic [OUT_W-1:0] comp_out [2];

    bfp_range_meter #(
        .IN_W      (IN_W),
        .OUT_W     (OUT_W),
        .MAX_SHIFT (MAX_SHIFT),
        .BLOCK_LEN (BLOCK_LEN)
    ) u_meter (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_last      (in_last),
        .in_new_xform (in_new_xform),
        .in_final     (in_final),
        .in_re        (in_re),
        .in_im        (in_im),
        .wr_idx       (wr_idx),
        .wr_bank      (wr_bank),
        .launch       (launch),
        .launch_meta  (launch_meta)
    );

    bfp_block_store #(
        .IN_W      (IN_W),
        .BLOCK_LEN (BLOCK_LEN)
    ) u_store (
        .clk   (clk),
        .we    (in_valid),
        .wbank (wr_bank),
        .widx  (wr_idx),
        .wre   (in_re),
        .wim   (in_im),
        .rbank (rd_bank),
        .ridx  (rd_idx),
        .rre   (comp_in[0]),
        .rim   (comp_in[1])
    );

    for (genvar c = 0; c < 2; c++) begin : g_comp
        bfp_round_shift #(
            .IN_W  (IN_W),
            .OUT_W (OUT_W)
        ) u_round (
            .x  (comp_in[c]),
            .sh (rd_meta.shift),
            .y  (comp_out[c])
        );
    end

    bfp_exp_accum #(
        .EXP_W (EXP_W)
    ) u_exp (
        .clk     (clk),
        .rst     (rst),
        .launch  (launch),
        .meta    (launch_meta),
        .exp_acc (exp_acc)
    );

    assign rd_end = (rd_state == RD_RUN) && (rd_idx == LAST_IDX);

    // Drain sequencer: a launch always restarts at index 0 on the just-filled bank.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_state <= RD_IDLE;
            rd_idx   <= '0;
            rd_bank  <= 1'b0;
            rd_meta  <= '0;
        end else if (launch) begin
            rd_state <= RD_RUN;
            rd_idx   <= '0;
            rd_bank  <= wr_bank;
            rd_meta  <= launch_meta;
        end else if (rd_state == RD_RUN) begin
            rd_idx <= rd_end ? '0 : rd_idx + IDX_W'(1);
            if (rd_end) begin
                rd_state <= RD_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
            exp_valid <= 1'b0;
            exp_out   <= '0;
        end else begin
            out_valid <= (rd_state == RD_RUN);
            out_last  <= rd_end;
            out_re    <= comp_out[0];
            out_im    <= comp_out[1];
            exp_valid <= rd_end && rd_meta.final_blk;
            if (rd_end && rd_meta.final_blk) begin
                exp_out <= exp_acc;
            end
        end
    end

endmodule

// File: rtl/bfp_pass_scaler_chk.sv
module bfp_pass_scaler_chk
    import bfp_pkg::*;
#(
    parameter int MAX_SHIFT = 3,
    parameter int BLOCK_LEN = 16,
    parameter int IDX_W     = 4,
    parameter int EXP_W     = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_last,
    input logic [IDX_W-1:0] wr_idx,
    input logic             launch,
    input shift_t           launch_shift,
    input logic             out_valid,
    input logic             out_last,
    input logic             exp_valid,
    input logic [EXP_W-1:0] exp_out
);

    // R5
    last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R5
    drain_start_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |=> ##1 out_valid);

    // R5
    contiguous_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

    // R7
    exp_with_last_chk: assert property (@(posedge clk) disable iff (rst)
        exp_valid |-> out_last);

    // R8
    exp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(exp_out) |-> exp_valid);

    // R2
    shift_cap_chk: assert property (@(posedge clk) disable iff (rst)
        launch |-> (int'(launch_shift) <= MAX_SHIFT));

    // R9
    block_framing_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_last) |-> (wr_idx == IDX_W'(BLOCK_LEN - 1)));

endmodule

bind bfp_pass_scaler bfp_pass_scaler_chk #(
    .MAX_SHIFT (MAX_SHIFT),
    .BLOCK_LEN (BLOCK_LEN),
    .IDX_W     (IDX_W),
    .EXP_W     (EXP_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_last      (in_last),
    .wr_idx       (wr_idx),
    .launch       (launch),
    .launch_shift (launch_meta.shift),
    .out_valid    (out_valid),
    .out_last     (out_last),
    .exp_valid    (exp_valid),
    .exp_out      (exp_out)
);

// File: tb/bfp_pass_scaler_bench.sv
module bfp_pass_scaler_bench;

    localparam int OUT_W     = 16;
    localparam int MAX_SHIFT = 3;
    localparam int BLOCK_LEN = 16;
    localparam int EXP_W     = 6;
    localparam int IN_W      = OUT_W + MAX_SHIFT;
    localparam int PASSES    = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic             in_last = 1'b0;
    logic             in_new_xform = 1'b0;
    logic             in_final = 1'b0;
    logic [IN_W-1:0]  in_re = '0;
    logic [IN_W-1:0]  in_im = '0;
    logic             out_valid;
    logic             out_last;
    logic [OUT_W-1:0] out_re;
    logic [OUT_W-1:0] out_im;
    logic             exp_valid;
    logic [EXP_W-1:0] exp_out;

    always #10 clk = ~clk;

    bfp_pass_scaler #(
        .OUT_W     (OUT_W),
        .MAX_SHIFT (MAX_SHIFT),
        .BLOCK_LEN (BLOCK_LEN),
        .EXP_W     (EXP_W)
    ) u_bfp_pass_scaler (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_last      (in_last),
        .in_new_xform (in_new_xform),
        .in_final     (in_final),
        .in_re        (in_re),
        .in_im        (in_im),
        .out_valid    (out_valid),
        .out_last     (out_last),
        .out_re       (out_re),
        .out_im       (out_im),
        .exp_valid    (exp_valid),
        .exp_out      (exp_out)
    );

    typedef struct {
        int     at;
        longint re;
        longint im;
        bit     last;
        bit     ev;
        int     ex;
        string  tag;
    } item_t;

    int     cyc = 0;
    int     checks = 0;
    int     errors = 0;
    bit     done = 1'b0;
    item_t  q[$];
    int     exp_hold = 0;
    int     mdl_acc = 0;
    int     cap_n = 0;
    longint cap_re [BLOCK_LEN];
    longint cap_im [BLOCK_LEN];
    longint blk_re [BLOCK_LEN];
    longint blk_im [BLOCK_LEN];
    longint x0_re  [BLOCK_LEN];
    longint x0_im  [BLOCK_LEN];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, string what, longint act, longint expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    function automatic int pick_shift_ref();
        for (int s = 0; s <= MAX_SHIFT; s++) begin
            longint lim = longint'(1) << (OUT_W - 1 + s);
            bit ok = 1'b1;
            for (int i = 0; i < BLOCK_LEN; i++) begin
                if (blk_re[i] >= lim || blk_re[i] < -lim || blk_im[i] >= lim || blk_im[i] < -lim)
                    ok = 1'b0;
            end
            if (ok) return s;
        end
        return MAX_SHIFT;
    endfunction

    function automatic longint scale_ref(longint x, int s);
        longint t;
        longint hi = (longint'(1) << (OUT_W - 1)) - 1;
        t = (s == 0) ? x : ((x + (longint'(1) << (s - 1))) >>> s);
        if (t > hi) t = hi;
        if (t < -hi - 1) t = -hi - 1;
        return t;
    endfunction

    task automatic send_block(bit newx, bit fin, string tag);
        int s;
        int c0;
        s = pick_shift_ref();
        mdl_acc = (newx ? 0 : mdl_acc) + s;
        @(negedge clk);
        c0 = cyc;
        for (int i = 0; i < BLOCK_LEN; i++) begin
            item_t it;
            it.at   = c0 + BLOCK_LEN + 1 + i;
            it.re   = scale_ref(blk_re[i], s);
            it.im   = scale_ref(blk_im[i], s);
            it.last = (i == BLOCK_LEN - 1);
            it.ev   = fin && (i == BLOCK_LEN - 1);
            it.ex   = mdl_acc;
            it.tag  = tag;
            q.push_back(it);
        end
        for (int j = 0; j < BLOCK_LEN; j++) begin
            if (j > 0) @(negedge clk);
            in_valid     = 1'b1;
            in_re        = blk_re[j][IN_W-1:0];
            in_im        = blk_im[j][IN_W-1:0];
            in_last      = (j == BLOCK_LEN - 1);
            in_new_xform = (j == 0) ? newx : 1'b0;
            in_final     = fin;
        end
    endtask

    task automatic quiet(int n);
        @(negedge clk);
        in_valid     = 1'b0;
        in_last      = 1'b0;
        in_new_xform = 1'b0;
        in_final     = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic fill_rand(longint amp);
        for (int i = 0; i < BLOCK_LEN; i++) begin
            blk_re[i] = longint'($urandom_range(0, 32'(2 * amp))) - amp;
            blk_im[i] = longint'($urandom_range(0, 32'(2 * amp))) - amp;
        end
    endtask

    // Cycle-by-cycle comparison against the expected stream.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (q.size() > 0 && q[0].at == cyc) begin
                item_t it;
                it = q.pop_front();
                check("R5", "out_valid", longint'(out_valid), 1);
                check(it.tag, "out_re", longint'($signed(out_re)), it.re);
                check(it.tag, "out_im", longint'($signed(out_im)), it.im);
                check("R5", "out_last", longint'(out_last), longint'(it.last));
                if (it.ev) begin
                    check("R7", "exp_valid", longint'(exp_valid), 1);
                    exp_hold = it.ex;
                end else begin
                    check("R8", "exp_valid", longint'(exp_valid), 0);
                end
                cap_re[cap_n] = longint'($signed(out_re));
                cap_im[cap_n] = longint'($signed(out_im));
                cap_n = it.last ? 0 : cap_n + 1;
            end else begin
                check("R5", "idle out_valid", longint'(out_valid), 0);
                check("R8", "idle exp_valid", longint'(exp_valid), 0);
            end
            check("R6", "exp_out", longint'(exp_out), longint'(exp_hold));
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog: actual %0d expected %0d", cyc, 0);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", longint'(out_valid), 0);
        check("R1", "out_last in reset", longint'(out_last), 0);
        check("R1", "exp_valid in reset", longint'(exp_valid), 0);
        check("R1", "exp_out in reset", longint'(exp_out), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "out_valid after reset", longint'(out_valid), 0);
        check("R1", "exp_out after reset", longint'(exp_out), 0);

        // R2: data already in range, shift 0, including both range edges
        fill_rand(30000);
        blk_re[0] = 32767;
        blk_im[0] = -32768;
        send_block(1'b1, 1'b1, "R2");
        quiet(BLOCK_LEN + 4);
        check("R2", "exponent of in-range block", longint'(exp_out), 0);

        // R3: shift 1 with half-way values of both signs
        fill_rand(20000);
        blk_re[0] = 40000;  blk_im[0] = 3;
        blk_re[1] = -3;     blk_im[1] = 1;
        blk_re[2] = -1;     blk_im[2] = 7;
        blk_re[3] = -7;     blk_im[3] = -65536;
        send_block(1'b1, 1'b1, "R3");
        quiet(BLOCK_LEN + 4);
        check("R3", "exponent of shift-1 block", longint'(exp_out), 1);

        // R4: saturation at shift 3, then at shift 2 and shift 1
        fill_rand(200000);
        blk_re[0] = 262143;  blk_im[0] = -262144;
        blk_re[1] = 262140;  blk_im[1] = 262139;
        send_block(1'b1, 1'b1, "R4");
        quiet(BLOCK_LEN + 4);
        check("R4", "exponent of shift-3 block", longint'(exp_out), 3);
        fill_rand(100000);
        blk_re[0] = 131071;  blk_im[0] = -131072;
        send_block(1'b1, 1'b1, "R4");
        quiet(BLOCK_LEN + 4);
        fill_rand(30000);
        blk_re[0] = 65535;   blk_im[0] = 65534;
        send_block(1'b1, 1'b1, "R4");
        quiet(BLOCK_LEN + 4);

        // R9: three blocks back to back with different shifts
        fill_rand(250000);
        send_block(1'b1, 1'b1, "R9");
        fill_rand(10000);
        send_block(1'b1, 1'b1, "R9");
        fill_rand(60000);
        send_block(1'b1, 1'b1, "R9");
        quiet(BLOCK_LEN + 4);

        // R6, R7, R8, R10: multi-pass transform, growth of 4 between passes
        fill_rand(100000);
        blk_re[5] = -131072;
        for (int i = 0; i < BLOCK_LEN; i++) begin
            x0_re[i] = blk_re[i];
            x0_im[i] = blk_im[i];
        end
        for (int p = 0; p < PASSES; p++) begin
            if (p > 0) begin
                for (int i = 0; i < BLOCK_LEN; i++) begin
                    blk_re[i] = cap_re[i] * 4;
                    blk_im[i] = cap_im[i] * 4;
                end
            end
            send_block(p == 0, p == PASSES - 1, "R3");
            quiet(BLOCK_LEN + 4);
            if (p < PASSES - 1)
                check("R8", "exponent untouched by non-final pass", longint'(exp_out), 1);
        end
        check("R6", "summed exponent over passes", longint'(exp_out), 6);
        for (int i = 0; i < BLOCK_LEN; i++) begin
            longint full_re = x0_re[i] * (longint'(1) << (2 * (PASSES - 1)));
            longint full_im = x0_im[i] * (longint'(1) << (2 * (PASSES - 1)));
            longint v_re = cap_re[i] << exp_out;
            longint v_im = cap_im[i] << exp_out;
            longint tol = longint'(PASSES) << exp_out;
            longint d_re = (v_re > full_re) ? v_re - full_re : full_re - v_re;
            longint d_im = (v_im > full_im) ? v_im - full_im : full_im - v_im;
            check("R10", "real error within bound", longint'(d_re <= tol), 1);
            check("R10", "imag error within bound", longint'(d_im <= tol), 1);
        end

        // R6: a new transform clears the sum, a later block adds to it
        fill_rand(20000);
        send_block(1'b1, 1'b1, "R6");
        quiet(BLOCK_LEN + 4);
        check("R6", "cleared exponent", longint'(exp_out), 0);
        fill_rand(50000);
        blk_re[0] = 60000;
        send_block(1'b0, 1'b1, "R6");
        quiet(BLOCK_LEN + 4);
        check("R6", "continued exponent", longint'(exp_out), 1);
        check("R5", "queue drained", longint'(q.size()), 0);

        finish_run();
    end

endmodule